// File: doc/BRIEF.md
# Sniff Duty-Cycle Sequencer

This block runs a radio receiver on a low duty cycle from a slow RC clock of about 10 kHz. While sniffing is enabled it holds the receiver and the crystal oscillator off for a programmed sleep time. It then powers both up and waits a settling dwell and a further RSSI delay. After that it compares an 8-bit digitized signal-strength sample against a threshold in a single decision cycle. If there is no energy, it goes straight back to sleep and restarts the sleep time. If there is energy, it keeps the receiver on, waits a data-sampling delay, and raises a wake indication for a programmed number of cycles. It then stays in receive until sniffing is disabled.

The sleep time is counted in steps produced by a prescaler. A fine step is `STEP_FINE` clock cycles (5, about 0.5 ms) and a coarse step is `STEP_COARSE` cycles (640, about 64 ms). A one-bit resolution input picks the step, and the block samples it when it enters sleep. Every other delay is counted in clock cycles. The block samples each count field when it enters the state that uses it.

States: `ST_IDLE` (disabled), `ST_SLEEP`, `ST_DWELL` (receiver power-up), `ST_RSSI_WAIT`, `ST_CHECK` (one-cycle decision), `ST_DATA_WAIT`, `ST_WAKE` (indication active) and `ST_LISTEN` (receive hold). The transitions are as follows:
- idle→sleep when enabled.
- sleep→dwell when the last step ends.
- dwell→rssi-wait and rssi-wait→check when their counts expire.
- check→data-wait when energy is detected.
- check→sleep when no energy is detected.
- data-wait→wake and wake→listen when their counts expire.
- any state→idle when sniffing is disabled.

Top module: `sniff_sequencer`

## Requirements
- R1: Sleep lasts `sleep_steps` × step clock cycles. The step is `STEP_FINE` when `coarse_step`=0 and `STEP_COARSE` when `coarse_step`=1, with `coarse_step` sampled on entry to sleep.
- R2: While idle or asleep, `rx_en` and `xtal_en` are both 0.
- R3: When sleep ends, `rx_en` and `xtal_en` are 1 for `dwell_cycles` cycles, then `rssi_delay` cycles, then one decision cycle.
- R4: In the decision cycle, the block detects energy only if `wake_on_rssi`=1 and `rssi` > `sniff_thresh`, unsigned and strictly greater. An equal value does not wake it.
- R5: If no energy is detected, both enables drop on the next edge and a full new sleep time starts.
- R6: After energy is detected, the receiver stays on with `wake_evt`=0 for `data_delay` cycles. Then `wake_evt` is 1 for exactly `irq_cycles` cycles.
- R7: After the wake indication ends, `rx_en` and `xtal_en` stay 1 and `wake_evt` stays 0 until sniffing is disabled.
- R8: When `sniff_en` is 0 at a clock edge, the block is idle after that edge with all outputs 0. From idle it enters sleep on the first edge with `sniff_en`=1. Reset forces idle.
- R9: A count field of 0 behaves as a count of 1.
- R10: `rx_en` and `xtal_en` are always equal, and `wake_evt` is 1 only while `rx_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC-derived sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sniff_en | input | 1 | Enables duty-cycled sniffing |
| coarse_step | input | 1 | Sleep step select: 0 fine, 1 coarse |
| sleep_steps | input | CNT_W | Sleep time in steps |
| dwell_cycles | input | CNT_W | Receiver power-up dwell |
| rssi_delay | input | CNT_W | Delay before the energy check |
| data_delay | input | CNT_W | Delay from detection to data sampling |
| irq_cycles | input | CNT_W | Width of the wake indication |
| wake_on_rssi | input | 1 | Allows a wake on energy |
| sniff_thresh | input | RSSI_W | Energy threshold |
| rssi | input | RSSI_W | Digitized signal-strength sample |
| rx_en | output | 1 | Receiver enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| wake_evt | output | 1 | Wake indication |

## Verification
The bench builds the block with `STEP_FINE`=3 and `STEP_COARSE`=7 and keeps `CNT_W` and `RSSI_W` at 8. The short steps let a sleep at either resolution, and the exact step multiple, be counted within a few dozen cycles. The values also keep the two resolutions distinct. With these settings the bench reaches the following cases:
- the no-energy return;
- the threshold tie;
- wake-on-RSSI disabled;
- zero-valued counts;
- a disable during the receive hold.

A behavioural model tracks each phase and the cycles left in it, and the bench compares it with the outputs on every clock.

// File: rtl/sniff_pkg.sv
package sniff_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_DWELL,
        ST_RSSI_WAIT,
        ST_CHECK,
        ST_DATA_WAIT,
        ST_WAKE,
        ST_LISTEN
    } sniff_state_t;

    function automatic logic [7:0] at_least_one(input logic [7:0] v);
        return (v == 8'd0) ? 8'd1 : v;
    endfunction

endpackage

// File: rtl/sniff_prescaler.sv
module sniff_prescaler #(
    parameter int STEP_FINE   = 5,
    parameter int STEP_COARSE = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic coarse_in,
    output logic tick
);
    localparam int PRE_W = $clog2(STEP_COARSE + 1);
    localparam logic [PRE_W-1:0] FINE_LAST   = PRE_W'(STEP_FINE - 1);
    localparam logic [PRE_W-1:0] COARSE_LAST = PRE_W'(STEP_COARSE - 1);

    logic [PRE_W-1:0] pre_q;
    logic             coarse_q;
    logic [PRE_W-1:0] last_val;

    assign last_val = coarse_q ? COARSE_LAST : FINE_LAST;
    assign tick     = (pre_q == last_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= '0;
            coarse_q <= 1'b0;
        end else if (restart) begin
            pre_q    <= '0;
            coarse_q <= coarse_in;
        end else if (tick) begin
            pre_q    <= '0;
        end else begin
            pre_q    <= pre_q + 1'b1;
        end
    end

    // R1: the step counter never passes the selected step length
    p_step_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= last_val);

endmodule

// File: rtl/sniff_timer.sv
module sniff_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q <= CNT_W'(1));

    // R9: a loaded count is never zero
    p_load_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q != '0);

endmodule

// File: rtl/sniff_sequencer.sv
module sniff_sequencer
    import sniff_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RSSI_W      = 8,
    parameter int STEP_FINE   = 5,
    parameter int STEP_COARSE = 640
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sniff_en,
    input  logic              coarse_step,
    input  logic [CNT_W-1:0]  sleep_steps,
    input  logic [CNT_W-1:0]  dwell_cycles,
    input  logic [CNT_W-1:0]  rssi_delay,
    input  logic [CNT_W-1:0]  data_delay,
    input  logic [CNT_W-1:0]  irq_cycles,
    input  logic              wake_on_rssi,
    input  logic [RSSI_W-1:0] sniff_thresh,
    input  logic [RSSI_W-1:0] rssi,
    output logic              rx_en,
    output logic              xtal_en,
    output logic              wake_evt
);
    sniff_state_t     state, state_n;
    logic             step_tick;
    logic             tmr_load, tmr_dec, tmr_last;
    logic [CNT_W-1:0] tmr_val, tmr_count, raw_val;
    logic             energy_hit;

    assign energy_hit = wake_on_rssi && (rssi > sniff_thresh);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:      state_n = ST_SLEEP;
            ST_SLEEP:     if (step_tick && tmr_last) state_n = ST_DWELL;
            ST_DWELL:     if (tmr_last) state_n = ST_RSSI_WAIT;
            ST_RSSI_WAIT: if (tmr_last) state_n = ST_CHECK;
            ST_CHECK:     state_n = energy_hit ? ST_DATA_WAIT : ST_SLEEP;
            ST_DATA_WAIT: if (tmr_last) state_n = ST_WAKE;
            ST_WAKE:      if (tmr_last) state_n = ST_LISTEN;
            ST_LISTEN:    state_n = ST_LISTEN;
            default:      state_n = ST_IDLE;
        endcase
        if (!sniff_en) state_n = ST_IDLE;
    end

    // timer control: load on every state change with the entered state's count
    always_comb begin
        unique case (state_n)
            ST_SLEEP:     raw_val = sleep_steps;
            ST_DWELL:     raw_val = dwell_cycles;
            ST_RSSI_WAIT: raw_val = rssi_delay;
            ST_DATA_WAIT: raw_val = data_delay;
            ST_WAKE:      raw_val = irq_cycles;
            default:      raw_val = CNT_W'(1);
        endcase
        tmr_val  = (raw_val == '0) ? CNT_W'(1) : raw_val;
        tmr_load = (state_n != state);
        tmr_dec  = (state == ST_SLEEP) ? step_tick : 1'b1;
    end

    // outputs
    always_comb begin
        rx_en    = 1'b0;
        xtal_en  = 1'b0;
        wake_evt = 1'b0;
        unique case (state)
            ST_IDLE, ST_SLEEP: ;
            ST_DWELL, ST_RSSI_WAIT, ST_CHECK, ST_DATA_WAIT, ST_LISTEN: begin
                rx_en   = 1'b1;
                xtal_en = 1'b1;
            end
            ST_WAKE: begin
                rx_en    = 1'b1;
                xtal_en  = 1'b1;
                wake_evt = 1'b1;
            end
            default: ;
        endcase
    end

    sniff_prescaler #(
        .STEP_FINE  (STEP_FINE),
        .STEP_COARSE(STEP_COARSE)
    ) i_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (tmr_load && state_n == ST_SLEEP),
        .coarse_in(coarse_step),
        .tick     (step_tick)
    );

    sniff_timer #(
        .CNT_W(CNT_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .dec     (tmr_dec),
        .count   (tmr_count),
        .last    (tmr_last)
    );

    // R8: a cleared enable reaches idle on the next edge
    p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sniff_en |=> state == ST_IDLE);

    // R2: sleeping keeps the receiver and oscillator off
    p_sleep_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SLEEP |-> (!rx_en && !xtal_en));

    // R4: detected energy leads to the data delay
    p_hit_to_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && sniff_en && energy_hit) |=> state == ST_DATA_WAIT);

    // R5: a miss restarts a full sleep count
    p_miss_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && sniff_en && !energy_hit) |=>
        (state == ST_SLEEP && tmr_count == at_least_one($past(sleep_steps))));

    // R6: the wake indication only follows the data delay
    p_wake_after_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_evt) |-> $past(state) == ST_DATA_WAIT);

    // R10: the wake indication implies the receiver is on
    p_wake_with_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |-> rx_en);

endmodule

// File: tb/test_sniff_sequencer.sv
module test_sniff_sequencer;
    localparam int SF = 3;
    localparam int SC = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sniff_en = 1'b0, coarse_step = 1'b0, wake_on_rssi = 1'b0;
    logic [7:0] sleep_steps = 8'd0, dwell_cycles = 8'd0, rssi_delay = 8'd0;
    logic [7:0] data_delay = 8'd0, irq_cycles = 8'd0, sniff_thresh = 8'd0, rssi = 8'd0;
    logic rx_en, xtal_en, wake_evt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sniff_sequencer #(.CNT_W(8), .RSSI_W(8), .STEP_FINE(SF), .STEP_COARSE(SC)) i_sniff_sequencer (
        .clk(clk), .rst_n(rst_n), .sniff_en(sniff_en), .coarse_step(coarse_step),
        .sleep_steps(sleep_steps), .dwell_cycles(dwell_cycles), .rssi_delay(rssi_delay),
        .data_delay(data_delay), .irq_cycles(irq_cycles), .wake_on_rssi(wake_on_rssi),
        .sniff_thresh(sniff_thresh), .rssi(rssi),
        .rx_en(rx_en), .xtal_en(xtal_en), .wake_evt(wake_evt));

    // behavioural reference: phase number and cycles left in it
    int m_phase = 0;
    int m_left = 0;

    function automatic int one_min(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    task automatic m_enter(input int p);
        m_phase = p;
        case (p)
            1: m_left = one_min(sleep_steps) * (coarse_step ? SC : SF);
            2: m_left = one_min(dwell_cycles);
            3: m_left = one_min(rssi_delay);
            5: m_left = one_min(data_delay);
            6: m_left = one_min(irq_cycles);
            default: m_left = 1;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n || !sniff_en) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: m_enter(1);
                1, 2, 3, 5, 6: begin
                    m_left--;
                    if (m_left == 0) m_enter(m_phase == 1 ? 2 : m_phase == 3 ? 4 : m_phase + 1);
                end
                4: m_enter((wake_on_rssi && rssi > sniff_thresh) ? 5 : 1);
                default: ;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model (R2, R3, R6, R7, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rx_en == (m_phase >= 2), "R2,R3 rx_en vs model", rx_en, m_phase >= 2);
            check(wake_evt == (m_phase == 6), "R6 wake_evt vs model", wake_evt, m_phase == 6);
            check(xtal_en == rx_en, "R10 xtal_en equals rx_en", xtal_en, rx_en);
        end
    end

    task automatic cnt_rx(input logic lvl, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (rx_en != lvl || n > 5000) break;
            n++;
        end
    endtask

    task automatic cnt_wake(input logic lvl, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            if (wake_evt != lvl || n > 5000) break;
            n++;
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!rx_en && !xtal_en && !wake_evt, "R8 reset outputs", rx_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sequence A: fine sleep, miss, tie, then hit
        sleep_steps = 8'd4; dwell_cycles = 8'd2; rssi_delay = 8'd3;
        sniff_thresh = 8'd100; rssi = 8'd50; wake_on_rssi = 1'b1;
        data_delay = 8'd3; irq_cycles = 8'd4;
        sniff_en = 1'b1;
        cnt_rx(1'b0, n); check(n == 4 * SF, "R1 fine sleep length", n, 4 * SF);
        cnt_rx(1'b1, n); check(n == 5, "R3 dwell+delay+check", n + 1, 6);
        cnt_rx(1'b0, n); check(n == 4 * SF - 1, "R5 sleep restarted", n + 1, 4 * SF);
        rssi = 8'd100;
        cnt_rx(1'b1, n); check(n == 5, "R4 tie does not wake", n + 1, 6);
        rssi = 8'd101;
        cnt_rx(1'b0, n); check(n == 4 * SF - 1, "R5 sleep after tie", n + 1, 4 * SF);
        cnt_wake(1'b0, n); check(n == 8, "R6 on before wake", n + 1, 9);
        cnt_wake(1'b1, n); check(n == 3, "R6 wake width", n + 1, 4);
        n = 0;
        repeat (20) begin
            @(negedge clk);
            if (rx_en && xtal_en && !wake_evt) n++;
        end
        check(n == 20, "R7 receive hold", n, 20);
        sniff_en = 1'b0;
        @(negedge clk);
        check(!rx_en && !xtal_en && !wake_evt, "R8 disable to idle", rx_en, 0);
        repeat (3) @(negedge clk);
        check(!rx_en, "R2 idle keeps receiver off", rx_en, 0);

        // sequence B: coarse sleep, zero counts, wake disabled
        coarse_step = 1'b1; sleep_steps = 8'd2; dwell_cycles = 8'd0; rssi_delay = 8'd0;
        rssi = 8'd0;
        sniff_en = 1'b1;
        cnt_rx(1'b0, n); check(n == 2 * SC, "R1 coarse sleep length", n, 2 * SC);
        cnt_rx(1'b1, n); check(n == 2, "R9 zero dwell and delay", n + 1, 3);
        sleep_steps = 8'd0; coarse_step = 1'b0; wake_on_rssi = 1'b0; rssi = 8'd255;
        cnt_rx(1'b0, n); check(n == 2 * SC - 1, "R1 resolution sampled at entry", n + 1, 2 * SC);
        cnt_rx(1'b1, n); check(n == 2, "R4 wake_on_rssi off ignores energy", n + 1, 3);
        cnt_rx(1'b0, n); check(n == SF - 1, "R9 zero sleep count", n + 1, SF);
        sniff_en = 1'b0;
        @(negedge clk);
        check(!rx_en && !wake_evt, "R8 disable during dwell", rx_en, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule